// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Latch Register

This block turns a serial bit stream into a parallel word through two register layers. The first layer is a chain of stages: on each rising edge of an external shift strobe, the serial data bit is taken into stage 0 and every other stage takes the value of the stage below it. The second layer is a holding register. On a rising edge of a separate external latch strobe, it copies the whole chain at once, and it drives the parallel outputs. Because the top stage of the chain is also brought out as a cascade output, several blocks can be daisy-chained. Each layer has its own active-low clear.

All external strobes, clears and the data bit are asynchronous to the block, which runs on one fast system clock. Each of these inputs passes through a two-flop synchroniser, and a rising edge is seen when the last synchronised sample is 1 and the sample before it was 0. The data bit comes from the same synchronised sample as the shift-strobe edge. A synchronised clear that is low has priority over any edge on its own strobe.

Top module: `ser2par_latch`

## Requirements
- R1: After system reset, `par_out` is all zeros and `cas_out` is 0.
- R2: On each rising edge of `shift_strobe`, with the shift clear high, the chain shifts up by one position without inversion: `ser_in` enters stage 0, stage i moves into stage i+1, and `cas_out` always shows stage WIDTH-1.
- R3: `par_out` changes only on a latch-strobe rising edge or a holding clear. Shift-strobe edges leave it unchanged.
- R4: On a rising edge of `latch_strobe`, with the holding clear high, all WIDTH chain stages are copied into `par_out`. Stage i appears on `par_out[i]`.
- R5: Falling edges of either strobe have no effect on the chain or on `par_out`.
- R6: While `shift_clr_n` is low, the chain, and with it `cas_out`, reads 0. Shift-strobe edges are ignored, and `par_out` keeps its value.
- R7: While `latch_clr_n` is low, `par_out` reads 0 and latch-strobe edges are ignored. The chain keeps its contents, so a capture after the clear is released shows the stages as they were before the clear.
- R8: When the two strobes rise together, the holding register captures the chain as it was before that shift. The holding register therefore lags the chain by one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous system reset |
| shift_strobe | input | 1 | External shift clock, acts on its rising edge |
| latch_strobe | input | 1 | External holding-register clock, acts on its rising edge |
| ser_in | input | 1 | Serial data bit shifted into stage 0 |
| shift_clr_n | input | 1 | Active-low clear of the shift chain |
| latch_clr_n | input | 1 | Active-low clear of the holding register |
| par_out | output | WIDTH | Parallel word from the holding register |
| cas_out | output | 1 | Cascade output, the top chain stage |

## Verification
The bench ties both strobes together and checks that the captured word is the one from before the shift. A design that sampled the chain after the update would show a word one bit ahead. It pulses each strobe while its own clear is low. A design in which the clear did not win would load stale data, which becomes visible when the next capture is released. It also checks that the holding clear leaves the chain alone, by reading the chain through a later capture and through `cas_out`. At every strobe fall, it confirms that nothing moved, which catches a design that triggers on both edges.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;
  // bundle of asynchronous control/data inputs, synchronised together
  typedef struct packed {
    logic sh_clk;
    logic st_clk;
    logic din;
    logic sh_clr_n;
    logic st_clr_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/ser2par_sync.sv
module ser2par_sync #(
  parameter int N     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/ser2par_rise.sv
module ser2par_rise #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= lvl;

  assign rise = lvl & ~prev;
endmodule

// File: rtl/ser2par_chain.sv
module ser2par_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr_n,
  input  logic             din,
  output logic [WIDTH-1:0] stages
);
  function automatic logic [WIDTH-1:0] push_bit(input logic [WIDTH-1:0] cur,
                                                input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      stages <= '0;
    else if (!clr_n) stages <= '0;
    else if (adv)    stages <= push_bit(stages, din);
endmodule

// File: rtl/ser2par_hold.sv
module ser2par_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      q <= '0;
    else if (!clr_n) q <= '0;
    else if (cap)    q <= d;
endmodule

// File: rtl/ser2par_latch.sv
module ser2par_latch
  import ser2par_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_strobe,
  input  logic             latch_strobe,
  input  logic             ser_in,
  input  logic             shift_clr_n,
  input  logic             latch_clr_n,
  output logic [WIDTH-1:0] par_out,
  output logic             cas_out
);
  localparam int EDGE_N = 2;

  ctl_t raw_ctl, syn_ctl;
  logic [EDGE_N-1:0] edges;

  // named internal events used by the checker
  logic             sh_edge, st_edge;
  logic             sh_clr_s, st_clr_s, din_s;
  logic [WIDTH-1:0] stages;

  assign raw_ctl = '{sh_clk: shift_strobe, st_clk: latch_strobe, din: ser_in,
                     sh_clr_n: shift_clr_n, st_clr_n: latch_clr_n};

  ser2par_sync #(.N(CTL_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(syn_ctl)
  );

  ser2par_rise #(.N(EDGE_N)) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl({syn_ctl.st_clk, syn_ctl.sh_clk}), .rise(edges)
  );

  assign sh_edge  = edges[0];
  assign st_edge  = edges[1];
  assign sh_clr_s = syn_ctl.sh_clr_n;
  assign st_clr_s = syn_ctl.st_clr_n;
  assign din_s    = syn_ctl.din;

  ser2par_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst_n(rst_n), .adv(sh_edge), .clr_n(sh_clr_s), .din(din_s),
    .stages(stages)
  );

  ser2par_hold #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap(st_edge), .clr_n(st_clr_s), .d(stages),
    .q(par_out)
  );

  assign cas_out = stages[WIDTH-1];
endmodule

// File: rtl/ser2par_latch_chk.sv
module ser2par_latch_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sh_edge,
  input logic             st_edge,
  input logic             sh_clr_s,
  input logic             st_clr_s,
  input logic [WIDTH-1:0] stages,
  input logic [WIDTH-1:0] par_out,
  input logic             cas_out
);
  a_r2_cascade_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_edge && sh_clr_s) |=> cas_out == $past(stages[WIDTH-2]));

  a_r6_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_edge && sh_clr_s) |=> $stable(stages));

  a_r6_chain_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_clr_s |=> (stages == '0 && !cas_out));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_edge && st_clr_s) |=> $stable(par_out));

  a_r7_hold_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr_s |=> par_out == '0);

  a_r8_capture_prior: assert property (@(posedge clk) disable iff (!rst_n)
    (st_edge && st_clr_s) |=> par_out == $past(stages));
endmodule

bind ser2par_latch ser2par_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_edge(sh_edge), .st_edge(st_edge),
  .sh_clr_s(sh_clr_s), .st_clr_s(st_clr_s), .stages(stages),
  .par_out(par_out), .cas_out(cas_out)
);

// File: tb/ser2par_latch_bench.sv
module ser2par_latch_bench;
  localparam int W      = 8;
  localparam int SETTLE = 5;

  logic clk = 0, rst_n = 0;
  logic shift_strobe = 0, latch_strobe = 0, ser_in = 0;
  logic shift_clr_n = 1, latch_clr_n = 1;
  logic [W-1:0] par_out;
  logic cas_out;

  always #10 clk = ~clk;

  ser2par_latch #(.WIDTH(W)) u_ser2par_latch (
    .clk(clk), .rst_n(rst_n), .shift_strobe(shift_strobe),
    .latch_strobe(latch_strobe), .ser_in(ser_in), .shift_clr_n(shift_clr_n),
    .latch_clr_n(latch_clr_n), .par_out(par_out), .cas_out(cas_out)
  );

  // reference model
  logic [W-1:0] m_chain = '0, m_hold = '0;

  // scoreboard
  logic [W:0] exp_q[$];
  string      tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_now(input string tag);
    repeat (SETTLE) @(posedge clk);
    exp_q.push_back({m_chain[W-1], m_hold});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if ({cas_out, par_out} !== e) begin
          n_bad++;
          $display("FAIL %s: actual cas=%b par=%h expected cas=%b par=%h",
                   t, cas_out, par_out, e[W], e[W-1:0]);
        end
      end
    end
  end

  // raise the chosen strobes, check, lower them, check nothing moved (R5)
  task automatic pulse(input bit sh, input bit st, input bit d, input string tag);
    logic [W-1:0] old_chain;
    @(negedge clk);
    ser_in = d;
    repeat (2) @(negedge clk);
    shift_strobe = sh;
    latch_strobe = st;
    old_chain = m_chain;
    if (sh) m_chain = shift_clr_n ? {m_chain[W-2:0], d} : '0;
    if (st) m_hold  = latch_clr_n ? old_chain : '0;
    expect_now(tag);
    shift_strobe = 0;
    latch_strobe = 0;
    expect_now("R5 falling edge ignored");
  endtask

  task automatic set_clears(input bit shc, input bit stc, input string tag);
    @(negedge clk);
    shift_clr_n = shc;
    latch_clr_n = stc;
    if (!shc) m_chain = '0;
    if (!stc) m_hold  = '0;
    expect_now(tag);
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) pulse(1, 0, w[i], "R2 shift R3 hold unchanged");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    expect_now("R1 reset state");

    shift_word(8'b1011_0011);
    pulse(0, 1, 0, "R4 capture whole chain");

    pulse(1, 0, 1, "R3 shift leaves par");
    pulse(1, 0, 0, "R3 shift leaves par");
    pulse(1, 1, 1, "R8 joint edge captures prior chain");
    pulse(1, 1, 0, "R8 joint edge lag");
    pulse(1, 1, 1, "R8 joint edge lag");

    set_clears(0, 1, "R6 chain cleared, par kept");
    pulse(1, 0, 1, "R6 shift ignored while cleared");
    set_clears(1, 1, "R6 release");
    pulse(0, 1, 0, "R6 chain stayed zero");

    shift_word(8'h5A);
    pulse(0, 1, 0, "R4 capture 5A");
    shift_word(8'hC3);
    set_clears(1, 0, "R7 hold cleared, chain kept");
    pulse(0, 1, 0, "R7 capture ignored while cleared");
    set_clears(1, 1, "R7 release");
    pulse(0, 1, 0, "R7 chain untouched by hold clear");

    set_clears(0, 0, "R6 R7 both cleared");
    set_clears(1, 1, "R1 idle after clears");

    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule